// File: doc/BRIEF.md
# Sponge Hash and Extendable-Output Engine

This block is an unkeyed sponge hashing engine built on a 320-bit state of five 64-bit words. The rate is one 64-bit word, and the engine runs its own permutation one round per clock. A pulse on `start` while the engine is idle loads one of two initial values. `xofMode` selects which one, so the fixed-length digest and the extendable-output function are kept apart by that value alone. The load is followed by a 12-round permutation.

After that, the engine takes the message as a stream of 64-bit words. The word carrying `msgLast` gives its count of valid bytes. The engine pads the message, absorbs each block, then squeezes output words over a valid/ready handshake. In fixed mode it returns four words (a 256-bit digest). In extendable-output mode it returns as many bytes as were requested at start, and a byte mask trims the final word.

A consumer can hold off any output word. The permutation that produces the next word starts only once the current word has been taken. The engine accepts no new operation until its last output word has been delivered.

Top module: `sponge_hash_engine`

## Requirements
- R1: While `rst_n` is low, and after it is released until a start, `msgReady` and `outValid` are low. Asserting reset during an operation abandons it.
- R2: A `start` sampled while idle loads word 0 with 0x0000080100cc0002 when `xofMode`=0, or with 0x0000080000cc0003 when `xofMode`=1. Words 1 to 4 are loaded with zero. The permutation then runs for 12 clocks, and `msgReady` is high after the 12th edge that follows the start edge.
- R3: Message byte k of a word sits in `msgData[8k+7:8k]` (little-endian). Every word without `msgLast` carries 8 bytes. Each accepted word is XORed into state word 0 and followed by 12 rounds, so `msgReady` is high again after the 12th edge that follows the accepting edge. While `msgReady` is high and `msgValid` is low, the state does not change.
- R4: On the last word with `msgBytes`=n<8, byte lanes n and above are ignored and byte lane n receives 0x01. When n=8, the word is absorbed whole and an extra block of 0x01 in lane 0 follows. The first output is valid 12 edges after the last accept (n<8) or 25 edges after it (n=8). An 8-byte-multiple message may also end with a last word of 0 bytes.
- R5: In fixed mode exactly four words are produced, all with `outMask`=0xFF, and `outLast` is set on the fourth.
- R6: In extendable-output mode, the byte count `outLen` sampled at start gives ceil(`outLen`/8) words. Bit k of `outMask` marks byte lane k. Every word has mask 0xFF except the last, whose mask has its low (`outLen` mod 8) bits set (0xFF when that is 0). `outLast` marks the final word.
- R7: In extendable-output mode with `outLen`=0, the engine returns to idle on the edge that accepts the last message word, and it produces no output.
- R8: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outMask` hold. After a non-final word is accepted, the next word is valid after the 12th following edge.
- R9: `start` is ignored except when idle. `msgReady` is low while output is pending, and both `msgReady` and `outValid` are low once the final word is accepted.
- R10: Each round adds a constant to the low byte of word 2 (0xF0, 0xE1, …, 0x4B, decreasing by 0x0F per round). It then applies the 5-bit substitution across the 64 bit slices, with word 0 as the slice MSB. Last, each word is XORed with two right rotations of itself: (19,28), (61,39), (1,6), (10,17), (7,41) for words 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| xofMode | input | 1 | 0 selects the fixed digest, 1 selects extendable output |
| outLen | input | LEN_W | Requested output length in bytes (extendable mode only) |
| msgValid | input | 1 | Message word is present |
| msgReady | output | 1 | Engine can absorb a message word |
| msgData | input | 64 | Message word, little-endian bytes |
| msgBytes | input | 4 | Valid bytes in the last word (0 to 8) |
| msgLast | input | 1 | Marks the final message word |
| outValid | output | 1 | Output word is present |
| outReady | input | 1 | Consumer takes the output word |
| outData | output | 64 | Output word, little-endian bytes |
| outMask | output | 8 | Byte-valid mask of the output word |
| outLast | output | 1 | Marks the final output word |

## Verification
Every result of this block is due a fixed number of edges after the edge that caused it:
- `msgReady` is due 12 edges after a start or a non-final accept.
- The first output word is due 12 edges after the last accept, or 25 edges when an extra padding block is needed.
- Each later output word is due 12 edges after the previous one is taken.

The bench drives inputs on falling edges and counts rising edges from the causing edge. It checks each latency against these exact numbers and samples data on the falling edge after the due edge. Output values are compared with a bench-side model of the padding, sponge and permutation. This model uses a lookup-table substitution, unlike the bitsliced form in the datapath.

// File: rtl/sponge_pkg.sv
package sponge_pkg;
  localparam int WORD_W     = 64;
  localparam int NUM_WORDS  = 5;
  localparam int LANE_BYTES = WORD_W / 8;
  localparam int NUM_ROUNDS = 12;
  localparam int RND_W      = 4;
  localparam int HASH_WORDS = 256 / WORD_W;
  localparam int BYTES_W    = $clog2(LANE_BYTES + 1);

  localparam logic [WORD_W-1:0] IV_FIXED = 64'h0000080100cc0002;
  localparam logic [WORD_W-1:0] IV_XOF   = 64'h0000080000cc0003;

  typedef logic [NUM_WORDS-1:0][WORD_W-1:0] state_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PERM, PH_ABSORB, PH_PAD, PH_SQUEEZE
  } phase_t;

  typedef struct packed {
    logic             loadIv;
    logic             ivXof;
    logic             xorMsg;
    logic             xorPad;
    logic             roundEn;
    logic [RND_W-1:0] roundIdx;
  } dpCtrl_t;

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction
endpackage

// File: rtl/sponge_round.sv
module sponge_round
  import sponge_pkg::*;
(
  input  state_t           sIn,
  input  logic [RND_W-1:0] roundIdx,
  output state_t           sOut
);
  localparam int ROT_A [NUM_WORDS] = '{19, 61, 1, 10, 7};
  localparam int ROT_B [NUM_WORDS] = '{28, 39, 6, 17, 41};

  logic [RND_W-1:0] k;
  logic [7:0]       rc;
  state_t           sub;

  always_comb begin
    logic [WORD_W-1:0] x0, x1, x2, x3, x4;
    logic [WORD_W-1:0] t0, t1, t2, t3, t4;
    k  = roundIdx + RND_W'(12 - NUM_ROUNDS);
    rc = {4'hf - k, k};
    x0 = sIn[0] ^ sIn[4];
    x4 = sIn[4] ^ sIn[3];
    x2 = sIn[2] ^ {56'd0, rc} ^ sIn[1];
    x1 = sIn[1];
    x3 = sIn[3];
    t0 = ~x0 & x1;
    t1 = ~x1 & x2;
    t2 = ~x2 & x3;
    t3 = ~x3 & x4;
    t4 = ~x4 & x0;
    x0 = x0 ^ t1;
    x1 = x1 ^ t2;
    x2 = x2 ^ t3;
    x3 = x3 ^ t4;
    x4 = x4 ^ t0;
    x1 = x1 ^ x0;
    x0 = x0 ^ x4;
    x3 = x3 ^ x2;
    sub[0] = x0;
    sub[1] = x1;
    sub[2] = ~x2;
    sub[3] = x3;
    sub[4] = x4;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gLinear
    assign sOut[w] = sub[w] ^ rotr(sub[w], ROT_A[w]) ^ rotr(sub[w], ROT_B[w]);
  end
endmodule

// File: rtl/sponge_datapath.sv
module sponge_datapath
  import sponge_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  dpCtrl_t            ctrl,
  input  logic [WORD_W-1:0]  msgData,
  input  logic [BYTES_W-1:0] msgBytes,
  input  logic               msgLast,
  output logic [WORD_W-1:0]  rateWord
);
  state_t            stateQ, stateD, roundOut;
  logic [WORD_W-1:0] paddedWord;

  sponge_round uRound (
    .sIn      (stateQ),
    .roundIdx (ctrl.roundIdx),
    .sOut     (roundOut)
  );

  always_comb begin
    for (int b = 0; b < LANE_BYTES; b++) begin
      if (!msgLast || BYTES_W'(b) < msgBytes)
        paddedWord[8*b +: 8] = msgData[8*b +: 8];
      else if (BYTES_W'(b) == msgBytes)
        paddedWord[8*b +: 8] = 8'h01;
      else
        paddedWord[8*b +: 8] = 8'h00;
    end
  end

  always_comb begin
    stateD = stateQ;
    if (ctrl.loadIv) begin
      stateD    = '0;
      stateD[0] = ctrl.ivXof ? IV_XOF : IV_FIXED;
    end else if (ctrl.xorMsg) begin
      stateD[0] = stateQ[0] ^ paddedWord;
    end else if (ctrl.xorPad) begin
      stateD[0] = stateQ[0] ^ 64'h1;
    end else if (ctrl.roundEn) begin
      stateD = roundOut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= '0;
    else        stateQ <= stateD;
  end

  assign rateWord = stateQ[0];
endmodule

// File: rtl/sponge_control.sv
module sponge_control
  import sponge_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               xofMode,
  input  logic [LEN_W-1:0]   outLen,
  input  logic               msgValid,
  input  logic               msgLast,
  input  logic [BYTES_W-1:0] msgBytes,
  input  logic               outReady,
  output logic               msgReady,
  output logic               outValid,
  output logic               outLast,
  output logic [LANE_BYTES-1:0] outMask,
  output dpCtrl_t            ctrl
);
  localparam int WL_W = LEN_W - 2;

  phase_t           phase, retPhase;
  logic [RND_W-1:0] rnd;
  logic             xofReg;
  logic [WL_W-1:0]  wordsLeft, reqWords;
  logic [LANE_BYTES-1:0] lastMask, tailMask;
  logic [LEN_W:0]   lenSum;
  logic [LANE_BYTES:0] tailShift;

  assign lenSum    = {1'b0, outLen} + (LEN_W+1)'(7);
  assign reqWords  = lenSum[LEN_W:3];
  assign tailShift = (LANE_BYTES+1)'(1) << outLen[2:0];
  assign tailMask  = (outLen[2:0] == 3'd0) ? '1 : LANE_BYTES'(tailShift - 1'b1);

  assign msgReady = (phase == PH_ABSORB);
  assign outValid = (phase == PH_SQUEEZE);
  assign outLast  = outValid && (wordsLeft == WL_W'(1));
  assign outMask  = outLast ? lastMask : '1;

  always_comb begin
    ctrl          = '0;
    ctrl.loadIv   = (phase == PH_IDLE) && start;
    ctrl.ivXof    = xofMode;
    ctrl.xorMsg   = (phase == PH_ABSORB) && msgValid;
    ctrl.xorPad   = (phase == PH_PAD);
    ctrl.roundEn  = (phase == PH_PERM);
    ctrl.roundIdx = rnd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      retPhase  <= PH_IDLE;
      rnd       <= '0;
      xofReg    <= 1'b0;
      wordsLeft <= '0;
      lastMask  <= '1;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          xofReg    <= xofMode;
          wordsLeft <= xofMode ? reqWords : WL_W'(HASH_WORDS);
          lastMask  <= xofMode ? tailMask : '1;
          rnd       <= '0;
          phase     <= PH_PERM;
          retPhase  <= PH_ABSORB;
        end
        PH_PERM: begin
          if (rnd == RND_W'(NUM_ROUNDS - 1)) begin
            rnd   <= '0;
            phase <= retPhase;
          end else begin
            rnd <= rnd + 1'b1;
          end
        end
        PH_ABSORB: if (msgValid) begin
          if (!msgLast) begin
            phase    <= PH_PERM;
            retPhase <= PH_ABSORB;
          end else if (wordsLeft == '0) begin
            phase <= PH_IDLE;
          end else begin
            phase    <= PH_PERM;
            retPhase <= (msgBytes >= BYTES_W'(LANE_BYTES)) ? PH_PAD : PH_SQUEEZE;
          end
        end
        PH_PAD: begin
          phase    <= PH_PERM;
          retPhase <= PH_SQUEEZE;
        end
        PH_SQUEEZE: if (outReady) begin
          wordsLeft <= wordsLeft - 1'b1;
          if (wordsLeft == WL_W'(1)) begin
            phase <= PH_IDLE;
          end else begin
            phase    <= PH_PERM;
            retPhase <= PH_SQUEEZE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start) |=> (!msgReady && !outValid)); // R2
  AST_FIXED_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !xofReg) |-> (outMask == 8'hff)); // R5
  AST_FINAL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && outLast) |=> (phase == PH_IDLE)); // R9
  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PERM) |-> (rnd < RND_W'(NUM_ROUNDS))); // R10
endmodule

// File: rtl/sponge_hash_engine.sv
module sponge_hash_engine
  import sponge_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             xofMode,
  input  logic [LEN_W-1:0] outLen,
  input  logic             msgValid,
  output logic             msgReady,
  input  logic [63:0]      msgData,
  input  logic [3:0]       msgBytes,
  input  logic             msgLast,
  output logic             outValid,
  input  logic             outReady,
  output logic [63:0]      outData,
  output logic [7:0]       outMask,
  output logic             outLast
);
  dpCtrl_t ctrl;

  sponge_control #(.LEN_W(LEN_W)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .xofMode  (xofMode),
    .outLen   (outLen),
    .msgValid (msgValid),
    .msgLast  (msgLast),
    .msgBytes (msgBytes),
    .outReady (outReady),
    .msgReady (msgReady),
    .outValid (outValid),
    .outLast  (outLast),
    .outMask  (outMask),
    .ctrl     (ctrl)
  );

  sponge_datapath uData (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .msgData  (msgData),
    .msgBytes (msgBytes),
    .msgLast  (msgLast),
    .rateWord (outData)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outMask))); // R8
  AST_WAIT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (msgReady && !msgValid) |=> (msgReady && $stable(outData))); // R3
  AST_MID_MASK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outLast) |-> (outMask == 8'hff)); // R6
  AST_NO_MSG_DURING_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !msgReady); // R9
endmodule

// File: tb/sponge_hash_engine_test.sv
`timescale 1ns/1ps
module sponge_hash_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        xofMode = 1'b0;
  logic [15:0] outLen = '0;
  logic        msgValid = 1'b0;
  logic        msgReady;
  logic [63:0] msgData = '0;
  logic [3:0]  msgBytes = '0;
  logic        msgLast = 1'b0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outData;
  logic [7:0]  outMask;
  logic        outLast;

  always #10 clk = ~clk;

  sponge_hash_engine #(.LEN_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .xofMode(xofMode), .outLen(outLen),
    .msgValid(msgValid), .msgReady(msgReady), .msgData(msgData), .msgBytes(msgBytes),
    .msgLast(msgLast), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outMask(outMask), .outLast(outLast)
  );

  int checks = 0;
  int errors = 0;

  localparam logic [4:0] SBOX [32] = '{
    5'h04, 5'h0b, 5'h1f, 5'h14, 5'h1a, 5'h15, 5'h09, 5'h02,
    5'h1b, 5'h05, 5'h08, 5'h12, 5'h1d, 5'h03, 5'h06, 5'h1c,
    5'h1e, 5'h13, 5'h07, 5'h0e, 5'h00, 5'h0d, 5'h11, 5'h18,
    5'h10, 5'h0c, 5'h01, 5'h19, 5'h16, 5'h0a, 5'h0f, 5'h17};
  localparam logic [7:0] RCON [12] = '{
    8'hf0, 8'he1, 8'hd2, 8'hc3, 8'hb4, 8'ha5, 8'h96, 8'h87, 8'h78, 8'h69, 8'h5a, 8'h4b};

  logic [63:0] st [5];
  logic [7:0]  msgBuf [128];
  logic [63:0] refOut [16];
  int          refCount;
  logic [7:0]  refTail;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [63:0] laneMask(input logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = m[b] ? 8'hff : 8'h00;
    return r;
  endfunction

  task automatic refPermute();
    for (int r = 0; r < 12; r++) begin
      st[2][7:0] = st[2][7:0] ^ RCON[r];
      for (int i = 0; i < 64; i++) begin
        logic [4:0] v;
        v = SBOX[{st[0][i], st[1][i], st[2][i], st[3][i], st[4][i]}];
        st[0][i] = v[4]; st[1][i] = v[3]; st[2][i] = v[2]; st[3][i] = v[1]; st[4][i] = v[0];
      end
      st[0] = st[0] ^ rr(st[0], 19) ^ rr(st[0], 28);
      st[1] = st[1] ^ rr(st[1], 61) ^ rr(st[1], 39);
      st[2] = st[2] ^ rr(st[2], 1)  ^ rr(st[2], 6);
      st[3] = st[3] ^ rr(st[3], 10) ^ rr(st[3], 17);
      st[4] = st[4] ^ rr(st[4], 7)  ^ rr(st[4], 41);
    end
  endtask

  task automatic buildRef(input bit xof, input int n, input int len);
    int off = 0;
    logic [63:0] w;
    st[0] = xof ? 64'h0000080000cc0003 : 64'h0000080100cc0002;
    for (int i = 1; i < 5; i++) st[i] = '0;
    refPermute();
    while (off + 8 <= n) begin
      for (int b = 0; b < 8; b++) w[8*b +: 8] = msgBuf[off + b];
      st[0] = st[0] ^ w;
      refPermute();
      off += 8;
    end
    w = '0;
    for (int b = 0; b < n - off; b++) w[8*b +: 8] = msgBuf[off + b];
    w[8*(n - off) +: 8] = 8'h01;
    st[0] = st[0] ^ w;
    refPermute();
    refCount = xof ? (len + 7) / 8 : 4;
    refTail  = (xof && (len % 8) != 0) ? 8'((9'h1 << (len % 8)) - 9'h1) : 8'hff;
    for (int i = 0; i < refCount; i++) begin
      refOut[i] = st[0];
      if (i < refCount - 1) refPermute();
    end
  endtask

  task automatic measure(output int n, input bit forValid);
    n = 0;
    while (!(forValid ? outValid : msgReady) && n < 60) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  task automatic startOp(input bit xof, input int len, input string tag);
    int n;
    @(negedge clk);
    start = 1'b1; xofMode = xof; outLen = 16'(len);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    measure(n, 1'b0);
    check(n == 12, {tag, " R2 ready latency after start"}, 64'(n), 64'd12);
  endtask

  task automatic sendMsg(input int n, input bit splitTail, input bit expectOut, input string tag);
    int full = n / 8;
    int rem  = n % 8;
    int nWords = (n == 0) ? 1 : ((rem != 0 || splitTail) ? full + 1 : full);
    for (int w = 0; w < nWords; w++) begin
      int bytesThis = (w < full) ? 8 : rem;
      bit last = (w == nWords - 1);
      int lat;
      msgValid = 1'b1; msgLast = last; msgBytes = 4'(bytesThis);
      for (int b = 0; b < 8; b++)
        msgData[8*b +: 8] = (b < bytesThis) ? msgBuf[8*w + b] : (8'ha5 ^ 8'(b * 17));
      while (!msgReady) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      msgValid = 1'b0; msgLast = 1'b0;
      if (!last) begin
        measure(lat, 1'b0);
        check(lat == 12, {tag, " R3 ready latency after word"}, 64'(lat), 64'd12);
      end else if (expectOut) begin
        measure(lat, 1'b1);
        check(lat == ((bytesThis == 8) ? 25 : 12), {tag, " R4 first output latency"},
              64'(lat), (bytesThis == 8) ? 64'd25 : 64'd12);
      end
    end
  endtask

  task automatic collect(input string tag, input bit stall);
    for (int i = 0; i < refCount; i++) begin
      logic [7:0] em = (i == refCount - 1) ? refTail : 8'hff;
      if (i > 0) begin
        int lat;
        measure(lat, 1'b1);
        check(lat == 12, {tag, " R8 next word latency"}, 64'(lat), 64'd12);
      end
      if (stall && i == 1) begin
        logic [63:0] held = outData;
        for (int c = 0; c < 4; c++) begin
          if (c == 0) begin start = 1'b1; xofMode = 1'b1; outLen = 16'd40; end
          @(posedge clk);
          @(negedge clk);
          start = 1'b0;
          check(outValid && outData == held, {tag, " R8 R9 word held under stall"}, outData, held);
        end
      end
      check((outData & laneMask(em)) == (refOut[i] & laneMask(em)), {tag, " R10 output word"},
            outData & laneMask(em), refOut[i] & laneMask(em));
      check(outMask == em, {tag, " R6 output mask"}, 64'(outMask), 64'(em));
      check(outLast == (i == refCount - 1), {tag, " R5 R6 last flag"}, 64'(outLast), 64'(i == refCount - 1));
      outReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      outReady = 1'b0;
    end
    for (int c = 0; c < 3; c++) begin
      check(!outValid && !msgReady, {tag, " R9 quiet after final word"}, {outValid, msgReady}, 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic runCase(input string tag, input bit xof, input int n, input int len,
                         input bit splitTail, input bit stall, input bit pulseAbsorb);
    for (int i = 0; i < 128; i++) msgBuf[i] = 8'(i * 7 + n * 13 + 1);
    buildRef(xof, n, len);
    startOp(xof, len, tag);
    if (pulseAbsorb) begin
      start = 1'b1; xofMode = ~xof; outLen = 16'd40;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check(msgReady && !outValid, {tag, " R9 start ignored in absorb"}, {outValid, msgReady}, 64'd1);
    end
    sendMsg(n, splitTail, refCount > 0, tag);
    if (refCount > 0) collect(tag, stall);
  endtask

  task automatic testReset();
    check(!msgReady && !outValid, "R1 idle after reset", {outValid, msgReady}, 64'd0);
    startOp(1'b0, 0, "reset");
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!msgReady && !outValid, "R1 reset abandons operation", {outValid, msgReady}, 64'd0);
    rst_n = 1'b1;
    runCase("after reset", 1'b0, 5, 0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testZeroLength();
    for (int i = 0; i < 128; i++) msgBuf[i] = 8'(i + 3);
    buildRef(1'b1, 5, 0);
    startOp(1'b1, 0, "zero length");
    sendMsg(5, 1'b0, 1'b0, "zero length");
    for (int c = 0; c < 20; c++) begin
      check(!outValid && !msgReady, "R7 no output for zero length", {outValid, msgReady}, 64'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    runCase("hash empty",       1'b0, 0,  0,  1'b0, 1'b0, 1'b0);
    runCase("hash 3 bytes R4",  1'b0, 3,  0,  1'b0, 1'b0, 1'b0);
    runCase("hash 8 bytes R4",  1'b0, 8,  0,  1'b0, 1'b0, 1'b0);
    runCase("hash 16 split R4", 1'b0, 16, 0,  1'b1, 1'b0, 1'b0);
    runCase("hash 20 bytes R3", 1'b0, 20, 0,  1'b0, 1'b1, 1'b1);
    runCase("xof 13 out R6",    1'b1, 11, 13, 1'b0, 1'b0, 1'b0);
    runCase("xof 24 out R2",    1'b1, 20, 24, 1'b0, 1'b1, 1'b1);
    runCase("xof 70 out R6",    1'b1, 40, 70, 1'b1, 1'b0, 1'b0);
    testZeroLength();
    runCase("hash after zero R7", 1'b0, 7, 0, 1'b0, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule